// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit sits beside a processor core and decides when the core takes an interrupt and at what priority. It keeps a pending mask, an enable mask and an 8-bit status word. The status word holds the current interrupt level in bits [3:0], an exception-mode flag in bit 4 and a user-mode flag in bit 5; bits 7:6 are stored but carry no meaning here. Each interrupt line has a fixed priority level taken from a parameter table. By default lines 0..7 are level 1, lines 8..10 are level 2 and the rest are level 3, so line 7 is a level-1 software line and line 11 is a level-3 software line.

Software acts through single-cycle request strobes. It can set or clear pending bits, write the enable mask, write the status word, atomically replace the level field (the old status word comes back), wait for an interrupt, write the per-level save registers, and return from a high-priority level. When an enabled line is eligible, the unit emits a one-cycle take pulse with the level, the line number and the vector. At the same edge it updates the status word. For levels above the exception-blocked range it also saves the old status and the interrupted address. Fetch and the pipeline see the unit only through the take, wait and return ports.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the status word, pending mask, enable mask, take pulse, wait flag and return pulse are all zero.
- R2: A set request ORs its mask into pending and a clear request removes its mask from pending. When both hit the same bit in one cycle, the clear wins.
- R3: A line whose enable bit is 0 is never taken, however long it stays pending.
- R4: A level-set request returns the full pre-request status word on `old_status` and writes only bits [3:0] of the status with the new level. Bits [7:4] are left unchanged.
- R5: Taking a level-1 line sets bit 4 of the status, leaves bits [3:0] at 0, loads `cause` with 4 and reports vector 0x300.
- R6: A level-1 line is taken when status bit 5 (user mode) is set. In that case the vector is 0x340 instead of 0x300.
- R7: Of all eligible lines, the one with the highest level is taken. Between equal levels, the lowest line number wins.
- R8: Taking a line of level L >= 2 sets the status to bits [7:5] unchanged, bit 4 set and level field L. The pre-entry status and `cur_pc` are saved in the level-L save slot. The vector is 0x180 + (L-2)*0x40.
- R9: A return request for level L >= 2 loads the status from the level-L saved status. It reports the level-L saved address on `ret_pc` with a one-cycle `ret_go`, including values that software wrote into the slot.
- R10: A wait request sets the level field to its operand and raises `waiting`. The flag stays high until an interrupt is taken, at which point it drops on the same edge as the take pulse.
- R11: A line of level L is eligible only if L is greater than status[3:0] and not (status bit 4 set and L <= 1).
- R12: No interrupt is taken on an edge where a status-changing or save-register request is present. The take happens on the following edge instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_set_en | input | 1 | Set-pending request |
| pend_set_mask | input | NUM_IRQ | Bits to set in pending |
| pend_clr_en | input | 1 | Clear-pending request |
| pend_clr_mask | input | NUM_IRQ | Bits to clear in pending |
| enable_we | input | 1 | Enable-mask write |
| enable_wdata | input | NUM_IRQ | New enable mask |
| stat_we | input | 1 | Status-word write |
| stat_wdata | input | 8 | New status word |
| lvl_set_en | input | 1 | Atomic level-set request |
| lvl_set_val | input | 4 | New level for the level-set request |
| old_status | output | 8 | Status word before the last level-set request |
| wait_en | input | 1 | Wait-for-interrupt request |
| wait_lvl | input | 4 | Level written by the wait request |
| waiting | output | 1 | High while waiting for an interrupt |
| ret_en | input | 1 | Return-from-interrupt request |
| ret_lvl | input | 4 | Level being returned from |
| ret_go | output | 1 | One-cycle pulse: return taken |
| ret_pc | output | ADDR_W | Address to resume at |
| cur_pc | input | ADDR_W | Address of the instruction that would be interrupted |
| take | output | 1 | One-cycle pulse: interrupt taken |
| take_level | output | 4 | Level of the taken line |
| take_id | output | clog2(NUM_IRQ) | Number of the taken line |
| take_vector | output | ADDR_W | Handler address |
| cause | output | 6 | Cause register |
| sv_status_we | input | 1 | Write the saved status of slot `sv_lvl` |
| sv_pc_we | input | 1 | Write the saved address of slot `sv_lvl` |
| sv_lvl | input | 4 | Level selecting the save slot to write |
| sv_wstatus | input | 8 | Saved-status write data |
| sv_wpc | input | ADDR_W | Saved-address write data |
| sv_rd_lvl | input | 4 | Level selecting the save slot to read |
| sv_rd_status | output | 8 | Saved status of slot `sv_rd_lvl`, one cycle later |
| sv_rd_pc | output | ADDR_W | Saved address of slot `sv_rd_lvl`, one cycle later |
| status | output | 8 | Current status word |
| pending | output | NUM_IRQ | Pending mask |
| enable | output | NUM_IRQ | Enable mask |

## Verification
The bench builds the unit with NUM_IRQ = 12 and MAX_LVL = 3, so every level (1, 2 and 3) has lines and the level-2 and level-3 save slots both exist. With this small set, the bench can try every line against every current level 0..3, with exception mode on and off. It can also try every pair of lines pending together, so eligibility and tie-breaking are covered in full. Expected levels, winners and vectors come from the default level rule and the vector arithmetic, not from the design.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int LVL_W   = 4;
  localparam int ST_W    = 8;
  localparam int MAX_IRQ = 32;

  typedef logic [LVL_W-1:0]         lvl_t;
  typedef logic [MAX_IRQ*LVL_W-1:0] lvl_table_t;

  typedef struct packed {
    logic [1:0] spare;
    logic       user;
    logic       exc;
    lvl_t       lvl;
  } status_t;

  function automatic lvl_t default_level(int idx);
    if (idx < 8)       return lvl_t'(1);
    else if (idx < 11) return lvl_t'(2);
    else               return lvl_t'(3);
  endfunction

  function automatic lvl_table_t default_levels();
    lvl_table_t t;
    t = '0;
    for (int i = 0; i < MAX_IRQ; i++) t[i*LVL_W +: LVL_W] = default_level(i);
    return t;
  endfunction
endpackage

// File: rtl/irq_dispatch_pend.sv
module irq_dispatch_pend #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic               clr_en,
  input  logic [NUM_IRQ-1:0] clr_mask,
  input  logic               en_we,
  input  logic [NUM_IRQ-1:0] en_wdata,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] en_q
);
  logic [NUM_IRQ-1:0] set_v, clr_v;

  assign set_v = set_en ? set_mask : '0;
  assign clr_v = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (set_en || clr_en) pend_q <= (pend_q | set_v) & ~clr_v;
      if (en_we) en_q <= en_wdata;
    end
  end
endmodule

// File: rtl/irq_dispatch_arb.sv
module irq_dispatch_arb
  import irq_dispatch_pkg::*;
#(
  parameter int         NUM_IRQ = 16,
  parameter int         IDW     = 4,
  parameter lvl_table_t LEVELS  = default_levels(),
  parameter lvl_t       EXC_LVL = 1
) (
  input  logic [NUM_IRQ-1:0] req,
  input  lvl_t               cur_lvl,
  input  logic               exc,
  output logic               found,
  output lvl_t               win_lvl,
  output logic [IDW-1:0]     win_id
);
  always_comb begin
    lvl_t lv;
    logic ok;
    found   = 1'b0;
    win_lvl = '0;
    win_id  = '0;
    lv      = '0;
    ok      = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      lv = LEVELS[i*LVL_W +: LVL_W];
      ok = req[i] && (lv > cur_lvl) && !(exc && (lv <= EXC_LVL));
      if (ok && (!found || lv >= win_lvl)) begin
        found   = 1'b1;
        win_lvl = lv;
        win_id  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_bank.sv
module irq_dispatch_bank
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOT0  = 2,
  parameter int NSLOT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_en,
  input  lvl_t              ent_lvl,
  input  status_t           ent_status,
  input  logic [ADDR_W-1:0] ent_pc,
  input  logic              st_we,
  input  logic              pc_we,
  input  lvl_t              wr_lvl,
  input  status_t           wr_status,
  input  logic [ADDR_W-1:0] wr_pc,
  input  lvl_t              rda_lvl,
  output status_t           rda_status,
  output logic [ADDR_W-1:0] rda_pc,
  input  lvl_t              rdb_lvl,
  output status_t           rdb_status,
  output logic [ADDR_W-1:0] rdb_pc
);
  status_t           st_all [NSLOT];
  logic [ADDR_W-1:0] pc_all [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam lvl_t SL = lvl_t'(SLOT0 + g);
    status_t           st_r;
    logic [ADDR_W-1:0] pc_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_r <= '0;
        pc_r <= '0;
      end else if (ent_en && ent_lvl == SL) begin
        st_r <= ent_status;
        pc_r <= ent_pc;
      end else begin
        if (st_we && wr_lvl == SL) st_r <= wr_status;
        if (pc_we && wr_lvl == SL) pc_r <= wr_pc;
      end
    end
    assign st_all[g] = st_r;
    assign pc_all[g] = pc_r;
  end

  always_comb begin
    rda_status = '0;
    rda_pc     = '0;
    rdb_status = '0;
    rdb_pc     = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (rda_lvl == lvl_t'(SLOT0 + s)) begin
        rda_status = st_all[s];
        rda_pc     = pc_all[s];
      end
      if (rdb_lvl == lvl_t'(SLOT0 + s)) begin
        rdb_status = st_all[s];
        rdb_pc     = pc_all[s];
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int                 NUM_IRQ       = 16,
  parameter int                 ADDR_W        = 32,
  parameter int                 MAX_LVL       = 3,
  parameter lvl_table_t         IRQ_LEVELS    = default_levels(),
  parameter lvl_t               EXC_LVL       = 1,
  parameter int                 CAUSE_W       = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_LOW     = 4,
  parameter logic [ADDR_W-1:0]  VEC_KERNEL    = 'h300,
  parameter logic [ADDR_W-1:0]  VEC_USER      = 'h340,
  parameter logic [ADDR_W-1:0]  VEC_HIGH_BASE = 'h180,
  parameter logic [ADDR_W-1:0]  VEC_STRIDE    = 'h40,
  localparam int                IDW           = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pend_set_en,
  input  logic [NUM_IRQ-1:0] pend_set_mask,
  input  logic               pend_clr_en,
  input  logic [NUM_IRQ-1:0] pend_clr_mask,
  input  logic               enable_we,
  input  logic [NUM_IRQ-1:0] enable_wdata,
  input  logic               stat_we,
  input  logic [ST_W-1:0]    stat_wdata,
  input  logic               lvl_set_en,
  input  logic [LVL_W-1:0]   lvl_set_val,
  output logic [ST_W-1:0]    old_status,
  input  logic               wait_en,
  input  logic [LVL_W-1:0]   wait_lvl,
  output logic               waiting,
  input  logic               ret_en,
  input  logic [LVL_W-1:0]   ret_lvl,
  output logic               ret_go,
  output logic [ADDR_W-1:0]  ret_pc,
  input  logic [ADDR_W-1:0]  cur_pc,
  output logic               take,
  output logic [LVL_W-1:0]   take_level,
  output logic [IDW-1:0]     take_id,
  output logic [ADDR_W-1:0]  take_vector,
  output logic [CAUSE_W-1:0] cause,
  input  logic               sv_status_we,
  input  logic               sv_pc_we,
  input  logic [LVL_W-1:0]   sv_lvl,
  input  logic [ST_W-1:0]    sv_wstatus,
  input  logic [ADDR_W-1:0]  sv_wpc,
  input  logic [LVL_W-1:0]   sv_rd_lvl,
  output logic [ST_W-1:0]    sv_rd_status,
  output logic [ADDR_W-1:0]  sv_rd_pc,
  output logic [ST_W-1:0]    status,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] enable
);
  localparam int SLOT0 = int'(EXC_LVL) + 1;
  localparam int NSLOT = MAX_LVL - int'(EXC_LVL);

  status_t           st_q;
  logic              busy, found, entry, ret_ok, low_entry;
  lvl_t              win_lvl;
  logic [IDW-1:0]    win_id;
  status_t           bank_a_st, bank_b_st;
  logic [ADDR_W-1:0] bank_a_pc, bank_b_pc;
  logic [ADDR_W-1:0] hi_vec;

  irq_dispatch_pend #(.NUM_IRQ(NUM_IRQ)) pend_i (
    .clk(clk), .rst(rst),
    .set_en(pend_set_en), .set_mask(pend_set_mask),
    .clr_en(pend_clr_en), .clr_mask(pend_clr_mask),
    .en_we(enable_we), .en_wdata(enable_wdata),
    .pend_q(pending), .en_q(enable)
  );

  irq_dispatch_arb #(
    .NUM_IRQ(NUM_IRQ), .IDW(IDW), .LEVELS(IRQ_LEVELS), .EXC_LVL(EXC_LVL)
  ) arb_i (
    .req(pending & enable), .cur_lvl(st_q.lvl), .exc(st_q.exc),
    .found(found), .win_lvl(win_lvl), .win_id(win_id)
  );

  assign busy      = stat_we | lvl_set_en | wait_en | ret_en | sv_status_we | sv_pc_we;
  assign entry     = found && !busy;
  assign low_entry = win_lvl <= EXC_LVL;
  assign ret_ok    = (ret_lvl >= lvl_t'(SLOT0)) && (ret_lvl <= lvl_t'(MAX_LVL));
  assign hi_vec    = VEC_HIGH_BASE + (ADDR_W'(win_lvl) - ADDR_W'(SLOT0)) * VEC_STRIDE;

  irq_dispatch_bank #(.ADDR_W(ADDR_W), .SLOT0(SLOT0), .NSLOT(NSLOT)) bank_i (
    .clk(clk), .rst(rst),
    .ent_en(entry && !low_entry), .ent_lvl(win_lvl), .ent_status(st_q), .ent_pc(cur_pc),
    .st_we(sv_status_we), .pc_we(sv_pc_we), .wr_lvl(sv_lvl),
    .wr_status(status_t'(sv_wstatus)), .wr_pc(sv_wpc),
    .rda_lvl(sv_rd_lvl), .rda_status(bank_a_st), .rda_pc(bank_a_pc),
    .rdb_lvl(ret_lvl), .rdb_status(bank_b_st), .rdb_pc(bank_b_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= '0;
      take         <= 1'b0;
      take_level   <= '0;
      take_id      <= '0;
      take_vector  <= '0;
      cause        <= '0;
      waiting      <= 1'b0;
      old_status   <= '0;
      ret_go       <= 1'b0;
      ret_pc       <= '0;
      sv_rd_status <= '0;
      sv_rd_pc     <= '0;
    end else begin
      take         <= entry;
      ret_go       <= 1'b0;
      sv_rd_status <= bank_a_st;
      sv_rd_pc     <= bank_a_pc;
      if (entry) begin
        take_level <= win_lvl;
        take_id    <= win_id;
        waiting    <= 1'b0;
        st_q.exc   <= 1'b1;
        if (low_entry) begin
          cause       <= CAUSE_LOW;
          st_q.lvl    <= '0;
          take_vector <= st_q.user ? VEC_USER : VEC_KERNEL;
        end else begin
          st_q.lvl    <= win_lvl;
          take_vector <= hi_vec;
        end
      end else if (ret_en) begin
        if (ret_ok) begin
          st_q   <= bank_b_st;
          ret_pc <= bank_b_pc;
          ret_go <= 1'b1;
        end
      end else if (lvl_set_en) begin
        old_status <= st_q;
        st_q.lvl   <= lvl_set_val;
      end else if (wait_en) begin
        st_q.lvl <= wait_lvl;
        waiting  <= 1'b1;
      end else if (stat_we) begin
        st_q <= status_t'(stat_wdata);
      end
    end
  end

  assign status = st_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int   NUM_IRQ = 16,
  parameter int   CAUSE_W = 6,
  parameter lvl_t EXC_LVL = 1,
  parameter logic [CAUSE_W-1:0] CAUSE_LOW = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               take,
  input logic [LVL_W-1:0]   take_level,
  input logic [CAUSE_W-1:0] cause,
  input logic [ST_W-1:0]    status,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] enable,
  input logic               lvl_set_en,
  input logic [LVL_W-1:0]   lvl_set_val,
  input logic               ret_en,
  input logic [ST_W-1:0]    old_status,
  input logic               waiting
);
  a_r3_only_enabled: assert property (@(posedge clk) disable iff (rst)
    take |-> ($past(pending & enable) != '0));

  a_r5_low_entry: assert property (@(posedge clk) disable iff (rst)
    (take && take_level <= EXC_LVL) |-> (status[4] && status[3:0] == '0 && cause == CAUSE_LOW));

  a_r8_high_entry: assert property (@(posedge clk) disable iff (rst)
    (take && take_level > EXC_LVL) |-> (status[4] && status[3:0] == take_level));

  a_r11_above_level: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_level > $past(status[3:0])));

  a_r4_level_set: assert property (@(posedge clk) disable iff (rst)
    ($past(lvl_set_en) && !$past(ret_en) && !$past(rst)) |->
      (old_status == $past(status) && status[3:0] == $past(lvl_set_val)
       && status[7:4] == $past(status[7:4])));

  a_r10_wait_drop: assert property (@(posedge clk) disable iff (rst)
    take |-> !waiting);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W), .EXC_LVL(EXC_LVL), .CAUSE_LOW(CAUSE_LOW)
) chk_i (
  .clk(clk), .rst(rst), .take(take), .take_level(take_level), .cause(cause),
  .status(status), .pending(pending), .enable(enable),
  .lvl_set_en(lvl_set_en), .lvl_set_val(lvl_set_val), .ret_en(ret_en),
  .old_status(old_status), .waiting(waiting)
);

// File: tb/irq_dispatch_tb_top.sv
module irq_dispatch_tb_top;
  localparam int N  = 12;
  localparam int AW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pend_set_en = 0, pend_clr_en = 0, enable_we = 0, stat_we = 0;
  logic lvl_set_en = 0, wait_en = 0, ret_en = 0, sv_status_we = 0, sv_pc_we = 0;
  logic [N-1:0] pend_set_mask = '0, pend_clr_mask = '0, enable_wdata = '0;
  logic [7:0] stat_wdata = '0, sv_wstatus = '0;
  logic [3:0] lvl_set_val = '0, wait_lvl = '0, ret_lvl = '0, sv_lvl = '0, sv_rd_lvl = '0;
  logic [AW-1:0] sv_wpc = '0, cur_pc = 32'h1234;
  logic [7:0] old_status, sv_rd_status, status;
  logic waiting, ret_go, take;
  logic [AW-1:0] ret_pc, take_vector, sv_rd_pc;
  logic [3:0] take_level;
  logic [IW-1:0] take_id;
  logic [5:0] cause;
  logic [N-1:0] pending, enable;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_dispatch #(.NUM_IRQ(N), .ADDR_W(AW), .MAX_LVL(3)) dut_i (
    .clk(clk), .rst(rst),
    .pend_set_en(pend_set_en), .pend_set_mask(pend_set_mask),
    .pend_clr_en(pend_clr_en), .pend_clr_mask(pend_clr_mask),
    .enable_we(enable_we), .enable_wdata(enable_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .lvl_set_en(lvl_set_en), .lvl_set_val(lvl_set_val), .old_status(old_status),
    .wait_en(wait_en), .wait_lvl(wait_lvl), .waiting(waiting),
    .ret_en(ret_en), .ret_lvl(ret_lvl), .ret_go(ret_go), .ret_pc(ret_pc),
    .cur_pc(cur_pc), .take(take), .take_level(take_level), .take_id(take_id),
    .take_vector(take_vector), .cause(cause),
    .sv_status_we(sv_status_we), .sv_pc_we(sv_pc_we), .sv_lvl(sv_lvl),
    .sv_wstatus(sv_wstatus), .sv_wpc(sv_wpc),
    .sv_rd_lvl(sv_rd_lvl), .sv_rd_status(sv_rd_status), .sv_rd_pc(sv_rd_pc),
    .status(status), .pending(pending), .enable(enable)
  );

  function automatic int lvl_of(int i);
    return (i < 8) ? 1 : ((i < 11) ? 2 : 3);
  endfunction

  function automatic logic [31:0] hi_vec(int l);
    return 32'h180 + 32'(l - 2) * 32'h40;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic op_stat(input logic [7:0] v);
    stat_we = 1; stat_wdata = v; tick(); stat_we = 0;
  endtask

  task automatic op_en(input logic [N-1:0] m);
    enable_we = 1; enable_wdata = m; tick(); enable_we = 0;
  endtask

  task automatic op_pend(input logic [N-1:0] s, input logic [N-1:0] c);
    pend_set_en = (s != '0); pend_set_mask = s;
    pend_clr_en = (c != '0); pend_clr_mask = c;
    tick();
    pend_set_en = 0; pend_clr_en = 0;
  endtask

  task automatic op_lvl(input logic [3:0] v);
    lvl_set_en = 1; lvl_set_val = v; tick(); lvl_set_en = 0;
  endtask

  task automatic op_sv(input logic [3:0] l, input logic [7:0] s, input logic [31:0] pc,
                       input bit ws, input bit wp);
    sv_lvl = l; sv_wstatus = s; sv_wpc = pc; sv_status_we = ws; sv_pc_we = wp;
    tick();
    sv_status_we = 0; sv_pc_we = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 status", status, 0);
    check("R1 pending", pending, 0);
    check("R1 enable", enable, 0);
    check("R1 take", take, 0);
    check("R1 waiting", waiting, 0);
    check("R1 ret_go", ret_go, 0);

    // R2 pending set/clear, R3 nothing taken while disabled
    op_pend(12'hFFF, '0);
    check("R2 set", pending, 12'hFFF);
    op_pend('0, 12'h0F0);
    check("R2 clear", pending, 12'hF0F);
    op_pend(12'h001, 12'h001);
    check("R2 clear wins", pending, 12'hF0E);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R3 disabled not taken", take, 0);
    end
    op_pend('0, 12'hFFF);
    check("R2 clear all", pending, 0);
    do_reset();
    op_pend(12'h880, '0);
    op_en(12'h001);
    tick();
    check("R3 other bit enabled only", take, 0);
    check("R3 status untouched", status, 0);

    // R11/R5/R8 sweep: every line x level 0..3 x exception mode
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 4; c++) begin
        for (int e = 0; e < 2; e++) begin
          int  l;
          bit  exp_t;
          l = lvl_of(i);
          exp_t = (l > c) && !(e == 1 && l <= 1);
          do_reset();
          op_stat(8'((e << 4) | c));
          op_en(N'(1) << i);
          op_pend(N'(1) << i, '0);
          tick();
          check("R11 eligibility", take, exp_t);
          if (exp_t) begin
            check("R7 id", take_id, i);
            check("R7 level", take_level, l);
            if (l == 1) begin
              check("R5 status", status, 8'h10);
              check("R5 cause", cause, 4);
              check("R5 vector", take_vector, 32'h300);
            end else begin
              check("R8 status", status, 8'(8'h10 | l));
              check("R8 vector", take_vector, hi_vec(l));
            end
          end
        end
      end
    end

    // R7 pair sweep
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        int w;
        w = (lvl_of(j) > lvl_of(i)) ? j : i;
        do_reset();
        op_en('1);
        op_pend((N'(1) << i) | (N'(1) << j), '0);
        tick();
        check("R7 take", take, 1);
        check("R7 winner", take_id, w);
        check("R7 winner level", take_level, lvl_of(w));
      end
    end

    // R6 user mode
    do_reset();
    op_stat(8'h20);
    op_en(12'h080);
    op_pend(12'h080, '0);
    tick();
    check("R6 taken", take, 1);
    check("R6 vector", take_vector, 32'h340);
    check("R6 status", status, 8'h30);
    check("R6 cause", cause, 4);

    // R4 level set
    do_reset();
    op_stat(8'h23);
    op_lvl(4'h7);
    check("R4 old", old_status, 8'h23);
    check("R4 new", status, 8'h27);
    op_stat(8'h3A);
    op_lvl(4'h0);
    check("R4 old2", old_status, 8'h3A);
    check("R4 new2", status, 8'h30);

    // R8 save + R9 return
    do_reset();
    cur_pc = 32'h0000_1234;
    op_en(12'h880);
    op_pend(12'h880, '0);
    tick();
    check("R8 take l3", take_level, 3);
    check("R8 status", status, 8'h13);
    sv_rd_lvl = 4'd3;
    tick();
    check("R8 saved status", sv_rd_status, 8'h00);
    check("R8 saved pc", sv_rd_pc, 32'h1234);
    op_sv(4'd3, 8'h23, 32'h0000_ABCD, 1, 1);
    ret_en = 1; ret_lvl = 4'd3; tick(); ret_en = 0;
    check("R9 ret_go", ret_go, 1);
    check("R9 ret_pc", ret_pc, 32'hABCD);
    check("R9 status", status, 8'h23);
    tick();
    check("R9 no retake", take, 0);
    check("R9 pulse", ret_go, 0);

    // R10 wait
    do_reset();
    op_stat(8'h05);
    op_en(12'h001);
    wait_en = 1; wait_lvl = 4'd0; tick(); wait_en = 0;
    check("R10 waiting", waiting, 1);
    check("R10 level", status, 8'h00);
    tick();
    tick();
    check("R10 still waiting", waiting, 1);
    op_pend(12'h001, '0);
    tick();
    check("R10 take", take, 1);
    check("R10 wait drop", waiting, 0);

    // R12 entry held off by a save write
    do_reset();
    op_en(12'h001);
    op_pend(12'h001, '0);
    op_sv(4'd2, 8'h00, 32'h0, 0, 1);
    check("R12 held", take, 0);
    tick();
    check("R12 next", take, 1);

    finish_run();
  end
endmodule